// File: doc/BRIEF.md
# Half-Bridge Switch Fault Supervisor

This block sits between a stored switch configuration and the gate drive of twelve power switches. The switches form six half-bridge pairs, each with one low-side and one high-side switch. A control word, written in one strobe, holds the requested on/off state of every switch and three protection enables. Bit 0 of the same word is a command that clears the latched diagnosis.

Per-switch overcurrent and open-load/underload comparator outputs arrive as digital levels. Each must stay asserted for its own qualification delay, counted in ticks of a shared prescaled microsecond timebase, before it turns off the affected switch. Once a switch has been turned off this way it stays off until a status reset. Chip-level supply undervoltage, supply overvoltage and over-temperature shutdown turn off every output while they are present. These chip-level conditions never erase the stored configuration, so the outputs come back on their own when the condition clears.

The block returns a diagnosis word. It holds sticky fault flags and a live image of the gated switch states. An active-low inhibit input, like the reset, wipes the configuration and all flags.

Top module: `hbridge_fault_sup`

## Requirements
- R1: An overcurrent input held through OC_DLY timebase ticks turns off only that switch and sets diagnosis bit 13. The switch stays off after the input drops, until a status reset.
- R2: An overcurrent or open-load input that drops before its delay has run out has no effect. Its qualification count restarts from zero, so two short pulses do not add up.
- R3: With control bit 13 = 0, overcurrent inputs neither turn off a switch nor set diagnosis bit 13.
- R4: An open-load input held through OL_DLY ticks turns off only that switch and sets diagnosis bit 14. With control bit 14 = 0, open-load inputs have no effect.
- R5: A supply undervoltage forces all outputs off while present and sets the sticky diagnosis bit 15. The configuration is kept, and the outputs return to it when the undervoltage ends, with no new write.
- R6: With control bit 15 = 1, a supply overvoltage forces all outputs off and sets diagnosis bit 15. With control bit 15 = 0, the overvoltage input is ignored.
- R7: Over-temperature shutdown forces all outputs off while present, leaves the diagnosis flags unchanged, and the outputs resume when it clears.
- R8: Temperature prewarning sets the sticky diagnosis bit 0 and does not change any output.
- R9: A control write with bit 0 = 1 clears diagnosis bits 15, 14, 13 and 0, and releases per-switch fault latches whose input has gone. The rest of the word is stored as usual.
- R10: Reset (rst_ni low) or inhibit (inhibit_ni low) turns every output off at once and clears the configuration and all diagnosis flags.
- R11: Control bit 2k-1 requests low-side switch k and drives sw_en_o[2k-2]. Control bit 2k requests high-side switch k and drives sw_en_o[2k-1]. Diagnosis bits 12..1 mirror sw_en_o[11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inhibit_ni | input | 1 | Active-low inhibit; clears all stored state and forces outputs off |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 16 | Control word: [15] ov lockout enable, [14] open-load enable, [13] overcurrent enable, [12:1] switch requests, [0] status reset |
| oc_flt_i | input | 12 | Per-switch overcurrent comparator level |
| ol_flt_i | input | 12 | Per-switch open-load/underload comparator level |
| uv_i | input | 1 | Supply undervoltage |
| ov_i | input | 1 | Supply overvoltage |
| tsd_i | input | 1 | Over-temperature shutdown |
| tpw_i | input | 1 | Temperature prewarning |
| sw_en_o | output | 12 | Gated switch enables |
| diag_o | output | 16 | Diagnosis: [15] supply fail, [14] open load, [13] overcurrent, [12:1] switch state, [0] prewarning |

## Verification
The hardest behaviour to reach from the ports is the restart of a qualification count. Two short fault pulses together would cross the delay, but neither does alone. The tick phase is not visible, so each pulse is held for fewer posedges than (delay-1) tick periods, and a gap of a few cycles separates the two. Only a counter that accumulates across the gap would turn the switch off. The bench also shrinks the prescaler and delays through parameters, so the latched-off state and its release by a status reset are reached in a few dozen cycles.

// File: rtl/hbsup_pkg.sv
package hbsup_pkg;

  typedef struct packed {
    logic sup;
    logic ol;
    logic oc;
    logic tpw;
  } diag_flags_t;

  localparam diag_flags_t FLAGS_CLEAR = '{sup: 1'b0, ol: 1'b0, oc: 1'b0, tpw: 1'b0};

endpackage

// File: rtl/hbsup_tick.sv
module hbsup_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2

endmodule

// File: rtl/hbsup_qual.sv
module hbsup_qual #(
  parameter int unsigned DLY = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  input  logic flt_i,
  input  logic rel_i,
  output logic lat_o,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(DLY + 1) > 0 ? $clog2(DLY + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt_q;
  logic          lat_q;
  logic          hit;

  assign hit = flt_i && en_i && (cnt_q == LIMIT);

  // count only while the fault is continuously present
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || !en_i || !flt_i)  cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lat_q <= 1'b0;
    else if (clr_i || !en_i)  lat_q <= 1'b0;
    else if (hit)             lat_q <= 1'b1;
    else if (rel_i)           lat_q <= 1'b0;
  end

  assign lat_o = lat_q;
  assign hit_o = hit;

  AST_QUAL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_i |=> (cnt_q == '0)); // R2
  AST_LATCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lat_q) |-> $past(flt_i && en_i)); // R1
  AST_LATCH_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lat_q); // R3

endmodule

// File: rtl/hbsup_diag.sv
module hbsup_diag
  import hbsup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        rel_i,
  input  logic        sup_set_i,
  input  logic        ol_set_i,
  input  logic        oc_set_i,
  input  logic        tpw_set_i,
  output diag_flags_t flags_o
);
  diag_flags_t flags_q, flags_d;

  always_comb begin
    flags_d     = rel_i ? FLAGS_CLEAR : flags_q;
    flags_d.sup = flags_d.sup | sup_set_i;
    flags_d.ol  = flags_d.ol  | ol_set_i;
    flags_d.oc  = flags_d.oc  | oc_set_i;
    flags_d.tpw = flags_d.tpw | tpw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= FLAGS_CLEAR;
    else if (clr_i)  flags_q <= FLAGS_CLEAR;
    else             flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !rel_i && flags_q.sup) |=> flags_q.sup); // R5

endmodule

// File: rtl/hbridge_fault_sup.sv
module hbridge_fault_sup
  import hbsup_pkg::*;
#(
  parameter int unsigned N_HB     = 6,
  parameter int unsigned TICK_DIV = 100,
  parameter int unsigned OC_DLY   = 25,
  parameter int unsigned OL_DLY   = 350
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inhibit_ni,
  input  logic                ctrl_we_i,
  input  logic [2*N_HB+3:0]   ctrl_i,
  input  logic [2*N_HB-1:0]   oc_flt_i,
  input  logic [2*N_HB-1:0]   ol_flt_i,
  input  logic                uv_i,
  input  logic                ov_i,
  input  logic                tsd_i,
  input  logic                tpw_i,
  output logic [2*N_HB-1:0]   sw_en_o,
  output logic [2*N_HB+3:0]   diag_o
);
  localparam int unsigned N_SW = 2 * N_HB;
  localparam int unsigned W    = N_SW + 4;
  localparam int unsigned B_OC = N_SW + 1;
  localparam int unsigned B_OL = N_SW + 2;
  localparam int unsigned B_OV = N_SW + 3;

  logic [W-1:1]    ctrl_q;
  logic [N_SW-1:0] sw_req, oc_lat, ol_lat, oc_hit, ol_hit;
  logic            tick, rel, inh_clr, oc_en, ol_en, ov_en, sup_flt, all_off;
  diag_flags_t     flags;

  assign inh_clr = !inhibit_ni;
  assign rel     = ctrl_we_i && ctrl_i[0] && inhibit_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (inh_clr)   ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_i[W-1:1];
  end

  assign sw_req = ctrl_q[N_SW:1];
  assign oc_en  = ctrl_q[B_OC];
  assign ol_en  = ctrl_q[B_OL];
  assign ov_en  = ctrl_q[B_OV];

  hbsup_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    hbsup_qual #(.DLY(OC_DLY)) u_oc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (inh_clr),
      .en_i   (oc_en),
      .tick_i (tick),
      .flt_i  (oc_flt_i[i]),
      .rel_i  (rel),
      .lat_o  (oc_lat[i]),
      .hit_o  (oc_hit[i])
    );
    hbsup_qual #(.DLY(OL_DLY)) u_ol (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (inh_clr),
      .en_i   (ol_en),
      .tick_i (tick),
      .flt_i  (ol_flt_i[i]),
      .rel_i  (rel),
      .lat_o  (ol_lat[i]),
      .hit_o  (ol_hit[i])
    );
  end

  // chip-level conditions gate outputs live; configuration untouched
  assign sup_flt = uv_i || (ov_i && ov_en);
  assign all_off = inh_clr || sup_flt || tsd_i;
  assign sw_en_o = all_off ? '0 : (sw_req & ~oc_lat & ~ol_lat);

  hbsup_diag u_diag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (inh_clr),
    .rel_i     (rel),
    .sup_set_i (sup_flt),
    .ol_set_i  (|ol_hit),
    .oc_set_i  (|oc_hit),
    .tpw_set_i (tpw_i),
    .flags_o   (flags)
  );

  assign diag_o = {flags.sup, flags.ol, flags.oc, sw_en_o, flags.tpw};

  AST_LATCHED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o & (oc_lat | ol_lat)) == '0); // R1
  AST_SUP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_ni && uv_i) |=> diag_o[W-1]); // R5
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_ni && !ctrl_we_i) |=> $stable(ctrl_q)); // R5
  AST_TPW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_ni && tpw_i) |=> diag_o[0]); // R8
  AST_INH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_ni |=> (ctrl_q == '0 && flags == FLAGS_CLEAR)); // R10

endmodule

// File: tb/sim_hbridge_fault_sup.sv
`timescale 1ns/1ps
module sim_hbridge_fault_sup;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, inhibit_ni = 1'b1, ctrl_we_i = 1'b0;
  logic [15:0] ctrl_i = '0;
  logic [11:0] oc_flt_i = '0, ol_flt_i = '0;
  logic        uv_i = 1'b0, ov_i = 1'b0, tsd_i = 1'b0, tpw_i = 1'b0;
  logic [11:0] sw_en_o;
  logic [15:0] diag_o;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  hbridge_fault_sup #(.N_HB(6), .TICK_DIV(4), .OC_DLY(5), .OL_DLY(12)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .inhibit_ni(inhibit_ni), .ctrl_we_i(ctrl_we_i),
    .ctrl_i(ctrl_i), .oc_flt_i(oc_flt_i), .ol_flt_i(ol_flt_i), .uv_i(uv_i),
    .ov_i(ov_i), .tsd_i(tsd_i), .tpw_i(tpw_i), .sw_en_o(sw_en_o), .diag_o(diag_o));

  function automatic logic [15:0] dg(input logic sup, ol, oc, input logic [11:0] sw, input logic tpw);
    return {sup, ol, oc, sw, tpw};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    ctrl_i = v; ctrl_we_i = 1'b1;
    @(negedge clk);
    ctrl_we_i = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R10 reset sw", {4'h0, sw_en_o}, 16'h0);
    chk("R10 reset diag", diag_o, 16'h0);
  endtask

  task automatic t_map;
    wr(16'h0002); chk("R11 ls1", {4'h0, sw_en_o}, 16'h0001);
    chk("R11 diag mirror", diag_o, dg(0, 0, 0, 12'h001, 0));
    wr(16'h0004); chk("R11 hs1", {4'h0, sw_en_o}, 16'h0002);
    wr(16'h1000); chk("R11 hs6", {4'h0, sw_en_o}, 16'h0800);
  endtask

  task automatic t_oc;
    wr(16'hFFFE); chk("R1 all on", {4'h0, sw_en_o}, 16'h0FFF);
    oc_flt_i[3] = 1'b1; step(24);
    chk("R1 oc off", diag_o, dg(0, 0, 1, 12'hFF7, 0));
    oc_flt_i[3] = 1'b0; step(5);
    chk("R1 oc held off", {4'h0, sw_en_o}, 16'h0FF7);
    wr(16'hFFFF);
    chk("R9 status reset", diag_o, dg(0, 0, 0, 12'hFFF, 0));
  endtask

  task automatic t_oc_short;
    oc_flt_i[5] = 1'b1; step(15);
    oc_flt_i[5] = 1'b0; step(3);
    oc_flt_i[5] = 1'b1; step(15);
    oc_flt_i[5] = 1'b0; step(2);
    chk("R2 short pulses", diag_o, dg(0, 0, 0, 12'hFFF, 0));
  endtask

  task automatic t_oc_dis;
    wr(16'hDFFE);
    oc_flt_i[0] = 1'b1; step(30);
    chk("R3 oc disabled", diag_o, dg(0, 0, 0, 12'hFFF, 0));
    oc_flt_i[0] = 1'b0;
    wr(16'hFFFE);
  endtask

  task automatic t_ol;
    ol_flt_i[10] = 1'b1; step(24);
    chk("R4 ol not yet", diag_o, dg(0, 0, 0, 12'hFFF, 0));
    step(30);
    chk("R4 ol off", diag_o, dg(0, 1, 0, 12'hBFF, 0));
    ol_flt_i[10] = 1'b0;
    wr(16'hFFFF);
    chk("R9 ol release", diag_o, dg(0, 0, 0, 12'hFFF, 0));
    wr(16'hBFFE);
    ol_flt_i[1] = 1'b1; step(60);
    chk("R4 ol disabled", diag_o, dg(0, 0, 0, 12'hFFF, 0));
    ol_flt_i[1] = 1'b0;
  endtask

  task automatic t_uv;
    wr(16'hF4B4); chk("R5 pattern", {4'h0, sw_en_o}, 16'h0A5A);
    uv_i = 1'b1; #1;
    chk("R5 uv off", {4'h0, sw_en_o}, 16'h0000);
    step(1);
    chk("R5 uv flag", diag_o, dg(1, 0, 0, 12'h000, 0));
    uv_i = 1'b0; #1;
    chk("R5 resume", {4'h0, sw_en_o}, 16'h0A5A);
    step(1);
    chk("R5 sticky", diag_o, dg(1, 0, 0, 12'hA5A, 0));
    wr(16'hF4B5);
    chk("R9 clear sup", diag_o, dg(0, 0, 0, 12'hA5A, 0));
  endtask

  task automatic t_ov;
    ov_i = 1'b1; #1;
    chk("R6 ov off", {4'h0, sw_en_o}, 16'h0000);
    step(1);
    chk("R6 ov flag", diag_o, dg(1, 0, 0, 12'h000, 0));
    ov_i = 1'b0;
    wr(16'h74B5);
    ov_i = 1'b1; step(3);
    chk("R6 ov ignored", diag_o, dg(0, 0, 0, 12'hA5A, 0));
    ov_i = 1'b0;
  endtask

  task automatic t_tsd;
    tsd_i = 1'b1; #1;
    chk("R7 tsd off", {4'h0, sw_en_o}, 16'h0000);
    step(2);
    chk("R7 no flag", diag_o, dg(0, 0, 0, 12'h000, 0));
    tsd_i = 1'b0; #1;
    chk("R7 resume", {4'h0, sw_en_o}, 16'h0A5A);
  endtask

  task automatic t_tpw;
    tpw_i = 1'b1; step(1); tpw_i = 1'b0; step(1);
    chk("R8 prewarn", diag_o, dg(0, 0, 0, 12'hA5A, 1));
    wr(16'h74B5);
    chk("R9 clear tpw", diag_o, dg(0, 0, 0, 12'hA5A, 0));
  endtask

  task automatic t_inh;
    tpw_i = 1'b1; step(1); tpw_i = 1'b0;
    inhibit_ni = 1'b0; #1;
    chk("R10 inh off", {4'h0, sw_en_o}, 16'h0000);
    step(2);
    inhibit_ni = 1'b1; #1;
    chk("R10 inh wiped", diag_o, 16'h0000);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    t_reset();
    t_map();
    t_oc();
    t_oc_short();
    t_oc_dis();
    t_ol();
    t_uv();
    t_ov();
    t_tsd();
    t_tpw();
    t_inh();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule